// File: doc/BRIEF.md
# Two-Bit Fault Pattern Sequencer

This block drives a fault-injection campaign against an attached round-based block cipher whose state is 128 bits. For each experiment it selects one pair of bits inside one byte of the state. It presents that pair as an XOR mask, and the cipher applies the mask to its state as the state enters the substitution step of a chosen round. Over one sweep the sequencer covers every unordered bit pair of every byte exactly once. With 16 bytes and 28 pairs per byte, a sweep is 448 experiments.

The cipher reports on each run through a result strobe that carries two bits. The first says whether the ciphertext differed from the fault-free one. The second says whether the cipher's own error checking raised its flag. The sequencer sorts each run into one of three outcomes: the output was still correct, the output was wrong but caught, or the output was wrong and went unnoticed. It keeps a saturating tally for each outcome and raises a done flag when the sweep is complete. The sequencer moves on to the next bit pair only after the result for the current run has arrived, so the cipher may take any number of cycles per run.

Top module: `fault_pair_sweeper`

## Requirements
- R1: After reset, `done` is low, all three tallies are zero, `mask_vld` is low and `fault_mask` is zero.
- R2: Bit pairs are visited in a fixed order, from outermost loop to innermost: row 0..3, then column 0..3, then low bit f = 0..6, then distance d = 1..7-f. The byte at (row, column) occupies `fault_mask` bits [8p+7:8p] with p = row + 4*column, and the pair sets bits 8p+f and 8p+f+d. The first three masks are therefore bits {0,1}, {0,2} and {0,3}, and the byte after byte 0 is byte 4.
- R3: While a sweep runs, `mask_vld` is high exactly when `sub_stage` is high and `cur_round` equals the latched target round, and in that case `fault_mask` has exactly two bits set. In every other cycle `fault_mask` is all zero and `mask_vld` is low.
- R4: `target_round` is sampled only in the cycle of `start`. A sampled value of 0 selects round 9.
- R5: The current bit pair is held until a `res_vld` pulse is accepted, however many cycles pass and however many rounds the cipher steps through.
- R6: An accepted result with `res_mismatch`=0 increments `cnt_correct`. With `res_mismatch`=1 and `res_detect`=1 it increments `cnt_caught`. With `res_mismatch`=1 and `res_detect`=0 it increments `cnt_silent`. No other tally changes.
- R7: Each tally saturates at 2^CNT_W-1 and stays there until the next `start`.
- R8: `start` clears all tallies and `done`, and restarts the sweep at the first pair. This holds even in the middle of a sweep. A result presented in the same cycle as `start` is discarded.
- R9: `done` rises in the cycle after the 448th accepted result and stays high until `start`. While `done` is high, results are ignored and the mask stays zero.
- R10: Before the first `start`, `res_vld` pulses leave the tallies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new sweep (one-cycle pulse) |
| target_round | input | 4 | Round to fault; 0 means round 9 |
| sub_stage | input | 1 | Cipher state is entering substitution this cycle |
| cur_round | input | 4 | Cipher's current round number |
| fault_mask | output | 128 | XOR mask for the substitution input |
| mask_vld | output | 1 | Mask is being applied this cycle |
| res_vld | input | 1 | Result strobe for the current run |
| res_mismatch | input | 1 | Ciphertext differs from the fault-free result |
| res_detect | input | 1 | Cipher raised its error flag |
| cnt_correct | output | 10 | Runs with correct output |
| cnt_caught | output | 10 | Runs that were wrong and flagged |
| cnt_silent | output | 10 | Runs that were wrong and not flagged |
| done | output | 1 | Sweep complete |

## Verification
The bench builds two instances side by side. One uses the default 10-bit tallies. The other is cut down to 6-bit tallies, so that each outcome class passes its ceiling of 63 within a single 448-run sweep. With this pair, the exact tally values and the saturation of R7 are both checked in the same full sweep. The other parameters stay at their defaults. That keeps the complete pair order, including the byte order of row then column, within a sweep of a few thousand cycles, and every mask in it is compared against the bench's own nested loops.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_RUN  = 2'd1,
        SW_DONE = 2'd2
    } sweep_state_e;

    typedef enum logic [1:0] {
        OC_CORRECT = 2'd0,
        OC_CAUGHT  = 2'd1,
        OC_SILENT  = 2'd2
    } outcome_e;

    localparam int NUM_OUTCOMES = 3;

    typedef struct packed {
        logic     hit;
        outcome_e cls;
    } tally_req_t;

    function automatic outcome_e classify(input logic mism, input logic det);
        if (!mism)    return OC_CORRECT;
        else if (det) return OC_CAUGHT;
        else          return OC_SILENT;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fps_walker.sv
module fps_walker #(
    parameter int N_ROWS = 4,
    parameter int N_COLS = 4,
    parameter int BYTE_W = 8,
    localparam int POS_W = fps_pkg::idx_w(N_ROWS * N_COLS * BYTE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    output logic [POS_W-1:0] lo_pos,
    output logic [POS_W-1:0] hi_pos,
    output logic             last
);
    localparam int RW    = fps_pkg::idx_w(N_ROWS);
    localparam int CW    = fps_pkg::idx_w(N_COLS);
    localparam int BIT_W = fps_pkg::idx_w(BYTE_W);

    localparam logic [RW-1:0]    ROW_MAX    = RW'(N_ROWS - 1);
    localparam logic [CW-1:0]    COL_MAX    = CW'(N_COLS - 1);
    localparam logic [BIT_W-1:0] FIRST_MAX  = BIT_W'(BYTE_W - 2);
    localparam logic [BIT_W:0]   TOP_BIT    = (BIT_W+1)'(BYTE_W - 1);
    localparam logic [POS_W-1:0] ROWS_P     = POS_W'(N_ROWS);
    localparam logic [POS_W-1:0] BYTE_P     = POS_W'(BYTE_W);

    logic [RW-1:0]    row_q;
    logic [CW-1:0]    col_q;
    logic [BIT_W-1:0] first_q;
    logic [BIT_W-1:0] dist_q;

    logic             pair_top;
    logic             byte_end;
    logic [POS_W-1:0] byte_pos;

    assign pair_top = ({1'b0, first_q} + {1'b0, dist_q}) == TOP_BIT;
    assign byte_end = pair_top && (first_q == FIRST_MAX);
    assign last     = byte_end && (row_q == ROW_MAX) && (col_q == COL_MAX);

    always_comb begin
        byte_pos = POS_W'(row_q) + ROWS_P * POS_W'(col_q);
        lo_pos   = byte_pos * BYTE_P + POS_W'(first_q);
        hi_pos   = lo_pos + POS_W'(dist_q);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            row_q   <= '0;
            col_q   <= '0;
            first_q <= '0;
            dist_q  <= BIT_W'(1);
        end else if (advance) begin
            if (!pair_top) begin
                dist_q <= dist_q + BIT_W'(1);
            end else begin
                dist_q <= BIT_W'(1);
                if (!byte_end) begin
                    first_q <= first_q + BIT_W'(1);
                end else begin
                    first_q <= '0;
                    if (col_q != COL_MAX) begin
                        col_q <= col_q + CW'(1);
                    end else begin
                        col_q <= '0;
                        row_q <= (row_q == ROW_MAX) ? '0 : row_q + RW'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fps_mask.sv
module fps_mask #(
    parameter int STATE_W = 128,
    localparam int POS_W  = fps_pkg::idx_w(STATE_W)
) (
    input  logic               en,
    input  logic [POS_W-1:0]   lo_pos,
    input  logic [POS_W-1:0]   hi_pos,
    output logic [STATE_W-1:0] mask
);
    for (genvar i = 0; i < STATE_W; i++) begin : g_bit
        assign mask[i] = en && ((lo_pos == POS_W'(i)) || (hi_pos == POS_W'(i)));
    end

endmodule

// File: rtl/fps_tally.sv
module fps_tally
    import fps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  tally_req_t req,
    output logic [NUM_OUTCOMES-1:0][CNT_W-1:0] counts
);
    localparam logic [CNT_W-1:0] SAT = '1;

    for (genvar g = 0; g < NUM_OUTCOMES; g++) begin : g_cnt
        logic bump;
        assign bump = req.hit && (req.cls == outcome_e'(g)) && (counts[g] != SAT);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                counts[g] <= '0;
            end else if (bump) begin
                counts[g] <= counts[g] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/fault_pair_sweeper.sv
module fault_pair_sweeper
    import fps_pkg::*;
#(
    parameter int N_ROWS    = 4,
    parameter int N_COLS    = 4,
    parameter int BYTE_W    = 8,
    parameter int CNT_W     = 10,
    parameter int ROUND_W   = 4,
    parameter int DEF_ROUND = 9,
    localparam int STATE_W  = N_ROWS * N_COLS * BYTE_W,
    localparam int POS_W    = idx_w(STATE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ROUND_W-1:0] target_round,
    input  logic               sub_stage,
    input  logic [ROUND_W-1:0] cur_round,
    output logic [STATE_W-1:0] fault_mask,
    output logic               mask_vld,
    input  logic               res_vld,
    input  logic               res_mismatch,
    input  logic               res_detect,
    output logic [CNT_W-1:0]   cnt_correct,
    output logic [CNT_W-1:0]   cnt_caught,
    output logic [CNT_W-1:0]   cnt_silent,
    output logic               done
);
    localparam logic [ROUND_W-1:0] DEF_R = ROUND_W'(DEF_ROUND);

    sweep_state_e       state_q;
    logic [ROUND_W-1:0] tgt_q;
    logic               running;
    logic               accept;
    logic               last_pair;
    logic [POS_W-1:0]   lo_pos;
    logic [POS_W-1:0]   hi_pos;
    tally_req_t         treq;
    logic [NUM_OUTCOMES-1:0][CNT_W-1:0] counts;

    assign running = (state_q == SW_RUN);
    assign accept  = running && res_vld && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            tgt_q   <= '0;
        end else if (start) begin
            state_q <= SW_RUN;
            tgt_q   <= (target_round == '0) ? DEF_R : target_round;
        end else if (accept && last_pair) begin
            state_q <= SW_DONE;
        end
    end

    fps_walker #(
        .N_ROWS (N_ROWS),
        .N_COLS (N_COLS),
        .BYTE_W (BYTE_W)
    ) u_walker (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .advance (accept),
        .lo_pos  (lo_pos),
        .hi_pos  (hi_pos),
        .last    (last_pair)
    );

    assign mask_vld = running && sub_stage && (cur_round == tgt_q);

    fps_mask #(
        .STATE_W (STATE_W)
    ) u_mask (
        .en     (mask_vld),
        .lo_pos (lo_pos),
        .hi_pos (hi_pos),
        .mask   (fault_mask)
    );

    always_comb begin
        treq.hit = accept;
        treq.cls = classify(res_mismatch, res_detect);
    end

    fps_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .req    (treq),
        .counts (counts)
    );

    assign cnt_correct = counts[OC_CORRECT];
    assign cnt_caught  = counts[OC_CAUGHT];
    assign cnt_silent  = counts[OC_SILENT];
    assign done        = (state_q == SW_DONE);

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int STATE_W = 128,
    parameter int CNT_W   = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               sub_stage,
    input logic [STATE_W-1:0] fault_mask,
    input logic               mask_vld,
    input logic               res_vld,
    input logic               res_mismatch,
    input logic [CNT_W-1:0]   cnt_correct,
    input logic [CNT_W-1:0]   cnt_caught,
    input logic [CNT_W-1:0]   cnt_silent,
    input logic               done
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R3
    mask_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mask_vld |-> $countones(fault_mask) == 2);

    // R3
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_vld |-> fault_mask == '0);

    // R3
    mask_stage_chk: assert property (@(posedge clk) disable iff (rst)
        mask_vld |-> sub_stage);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mask_vld);

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_correct == '0 && cnt_caught == '0 && cnt_silent == '0 && !done));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && cnt_silent == TOP) |=> cnt_silent == TOP);

    // R10
    no_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_vld && !start) |=> ($stable(cnt_correct) && $stable(cnt_caught) && $stable(cnt_silent)));

    // R6
    correct_only_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_mismatch && !start) |=> ($stable(cnt_caught) && $stable(cnt_silent)));

endmodule

bind fault_pair_sweeper fps_checker #(
    .STATE_W (STATE_W),
    .CNT_W   (CNT_W)
) u_fps_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .sub_stage    (sub_stage),
    .fault_mask   (fault_mask),
    .mask_vld     (mask_vld),
    .res_vld      (res_vld),
    .res_mismatch (res_mismatch),
    .cnt_correct  (cnt_correct),
    .cnt_caught   (cnt_caught),
    .cnt_silent   (cnt_silent),
    .done         (done)
);

// File: tb/test_fault_pair_sweeper.sv
`timescale 1ns/1ps
module test_fault_pair_sweeper;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   target_round = '0;
    logic         sub_stage = 1'b0;
    logic [3:0]   cur_round = '0;
    logic         res_vld = 1'b0;
    logic         res_mismatch = 1'b0;
    logic         res_detect = 1'b0;

    logic [127:0] fault_mask, n_mask;
    logic         mask_vld, n_vld;
    logic [9:0]   cnt_correct, cnt_caught, cnt_silent;
    logic [5:0]   n_correct, n_caught, n_silent;
    logic         done, n_done;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fault_pair_sweeper i_fault_pair_sweeper (
        .clk(clk), .rst(rst), .start(start), .target_round(target_round),
        .sub_stage(sub_stage), .cur_round(cur_round),
        .fault_mask(fault_mask), .mask_vld(mask_vld),
        .res_vld(res_vld), .res_mismatch(res_mismatch), .res_detect(res_detect),
        .cnt_correct(cnt_correct), .cnt_caught(cnt_caught), .cnt_silent(cnt_silent),
        .done(done)
    );

    fault_pair_sweeper #(.CNT_W(6)) i_fault_pair_sweeper_sat (
        .clk(clk), .rst(rst), .start(start), .target_round(target_round),
        .sub_stage(sub_stage), .cur_round(cur_round),
        .fault_mask(n_mask), .mask_vld(n_vld),
        .res_vld(res_vld), .res_mismatch(res_mismatch), .res_detect(res_detect),
        .cnt_correct(n_correct), .cnt_caught(n_caught), .cnt_silent(n_silent),
        .done(n_done)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] pair(input int r, input int c, input int f, input int d);
        int p;
        p = r + 4 * c;
        return (128'd1 << (8 * p + f)) | (128'd1 << (8 * p + f + d));
    endfunction

    task automatic counts(input string req, input int ec, input int ek, input int es);
        check({req, " correct"}, 128'(cnt_correct), 128'(ec));
        check({req, " caught"},  128'(cnt_caught),  128'(ek));
        check({req, " silent"},  128'(cnt_silent),  128'(es));
    endtask

    task automatic result(input logic mism, input logic det);
        res_vld = 1'b1; res_mismatch = mism; res_detect = det;
        tick();
        res_vld = 1'b0; res_mismatch = 1'b0; res_detect = 1'b0;
    endtask

    task automatic pulse_start(input logic [3:0] tr);
        target_round = tr;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // one experiment: step the cipher through rounds 1..10, then report
    task automatic experiment(input int tgt, input logic [127:0] exp, input logic mism, input logic det);
        for (int rr = 1; rr <= 10; rr++) begin
            sub_stage = 1'b1;
            cur_round = 4'(rr);
            #1;
            // R2 R3 mask appears only in the latched round
            check("R2/R3 mask", fault_mask, (rr == tgt) ? exp : 128'd0);
            check("R3 mask_vld", 128'(mask_vld), 128'(rr == tgt));
            tick();
        end
        sub_stage = 1'b0;
        cur_round = 4'(tgt);
        #1;
        check("R3 no stage", fault_mask, 128'd0);
        result(mism, det);
    endtask

    initial begin
        int k, nwrong, ec, ek, es;
        logic m, dt;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        sub_stage = 1'b1; cur_round = 4'd9;
        #1;
        check("R1 done", 128'(done), 128'd0);
        check("R1 mask", fault_mask, 128'd0);
        check("R1 mask_vld", 128'(mask_vld), 128'd0);
        counts("R1", 0, 0, 0);
        sub_stage = 1'b0;

        // R10 results before any sweep are ignored
        result(1'b1, 1'b0);
        result(1'b0, 1'b0);
        counts("R10", 0, 0, 0);

        // Full sweep, target 0 selects round 9 (R4); change input afterwards
        pulse_start(4'd0);
        target_round = 4'd3;
        k = 0; nwrong = 0; ec = 0; ek = 0; es = 0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 7; f++)
                    for (int d = 1; d <= 7 - f; d++) begin
                        if (k % 8 < 5) begin m = 1'b0; dt = 1'b0; ec++; end
                        else if (nwrong < 90) begin m = 1'b1; dt = 1'b1; ek++; nwrong++; end
                        else begin m = 1'b1; dt = 1'b0; es++; nwrong++; end
                        if (k == 447) check("R9 done before last", 128'(done), 128'd0);
                        experiment(9, pair(r, c, f, d), m, dt);
                        k++;
                    end
        // R6 classification totals, R9 done
        counts("R6", ec, ek, es);
        counts("R6 sweep", 280, 90, 78);
        check("R9 done", 128'(done), 128'd1);
        // R7 saturation of the narrow instance
        check("R7 sat correct", 128'(n_correct), 128'd63);
        check("R7 sat caught",  128'(n_caught),  128'd63);
        check("R7 sat silent",  128'(n_silent),  128'd63);
        // R9 results after done ignored, mask quiet
        result(1'b1, 1'b0);
        sub_stage = 1'b1; cur_round = 4'd9;
        #1;
        check("R9 mask after done", fault_mask, 128'd0);
        counts("R9 ignore", 280, 90, 78);
        check("R9 done held", 128'(done), 128'd1);
        sub_stage = 1'b0;

        // R8 start with simultaneous result: result discarded
        res_vld = 1'b1; res_mismatch = 1'b1; res_detect = 1'b0;
        pulse_start(4'd5);
        res_vld = 1'b0; res_mismatch = 1'b0;
        counts("R8 clear", 0, 0, 0);
        check("R8 done clear", 128'(done), 128'd0);
        check("R8 narrow clear", 128'(n_silent), 128'd0);
        target_round = 4'd0;

        // R4 latched round 5; R5 pattern held over idle cycles
        for (int rep = 0; rep < 3; rep++) begin
            sub_stage = 1'b1; cur_round = 4'd5;
            #1;
            check("R5 hold", fault_mask, pair(0, 0, 0, 1));
            cur_round = 4'd9;
            #1;
            check("R4 latched", fault_mask, 128'd0);
            tick();
        end
        sub_stage = 1'b0;
        result(1'b1, 1'b1);
        result(1'b1, 1'b1);
        result(1'b1, 1'b1);
        sub_stage = 1'b1; cur_round = 4'd5;
        #1;
        check("R2 fourth pair", fault_mask, pair(0, 0, 0, 4));
        sub_stage = 1'b0;
        counts("R6 caught", 0, 3, 0);

        // R8 restart mid-sweep
        pulse_start(4'd2);
        counts("R8 mid clear", 0, 0, 0);
        sub_stage = 1'b1; cur_round = 4'd2;
        #1;
        check("R8 restart pair", fault_mask, pair(0, 0, 0, 1));
        sub_stage = 1'b0;
        for (int i = 0; i < 30; i++) result(1'b1, 1'b0);
        counts("R6 silent", 0, 0, 30);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule